// File: doc/BRIEF.md
# Comparator Hit Counter Register Core

This block counts edges on a group of comparator outputs and presents the results on a 16-bit register bus with an 8-bit local address space. Each channel has its own 32-bit counter. A per-channel polarity bit selects whether that channel counts rising or falling edges. Every comparator line first passes through a two-flop synchroniser, and edge detection works on the synchronised level.

Software reads a consistent set of counts by setting a lock bit. When the lock bit goes from 0 to 1, every live count and the current 64-bit time value are copied into shadow storage in the same clock cycle. While the lock bit stays at 1, counter reads return the shadow copies. The live counters keep counting underneath, so no hit is lost. Any value wider than 16 bits is split across consecutive addresses, with the least significant slice at the lowest address.

The bus is a plain synchronous port. A write is taken on any clock edge where `reg_wr` is high. Read data is registered and shows the word at `reg_addr` one edge after that address is presented. There is no stalling in either direction.

Top module: `hitcnt_regcore`

## Requirements
- R1: Offset 00h reads 0xECE4 and offset 01h reads 0x2324. Together they form the 32-bit identifier 0x2324ECE4. Writes to these offsets change nothing.
- R2: Offset 03h holds the lock control in bit 0, which can be written and read back. Bits 15:1 of that offset always read as zero.
- R3: On a write that takes the lock bit from 0 to 1, all counts and the 64-bit time input are captured in that cycle. While the lock bit is 1, counter reads return the captured counts. Live counting goes on, and those counts become visible again once the lock bit is written to 0.
- R4: Offsets 04h to 07h return the captured 64-bit time value, bits 15:0 at 04h up to bits 63:48 at 07h. This value is held until the next lock rise.
- R5: Offset 08h returns the number of implemented channels (16 by default). Writes to it change nothing.
- R6: Offsets 10h to 17h return the synchronised comparator levels. Bit n of the 128-bit vector is channel n (bit n mod 16 of offset 10h + n/16). Bits for channels that are not implemented read as zero.
- R7: Offsets 18h to 1Fh form a 128-bit polarity mask laid out in the same way as R6. A 1 makes the channel count falling edges, and a 0 makes it count rising edges. Bits for channels that are not implemented read as zero and cannot be written.
- R8: Channel n's counter reads at offset 80h+2n (bits 15:0) and 80h+2n+1 (bits 31:16). Each qualifying edge adds exactly one. The count wraps modulo 2^32.
- R9: Reserved and unused offsets (for example 02h, 20h, A0h) read as zero, and writes to them change nothing.
- R10: A synchronous reset clears all counters, the captured counts, the captured time value, the polarity mask (all rising) and the lock bit.
- R11: Read data for an address appears on `reg_rdata` one clock edge after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | NUM_CH | Asynchronous comparator outputs, one per channel |
| time_now | input | 64 | Running time value captured on lock |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Local register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
A change on a comparator line reaches the readable level after two edges and adds to the counter on the third. The bench therefore waits four cycles after each input change before it reads. Every read presents the address at a falling edge and samples `reg_rdata` at the next falling edge, which is one registered edge later. The lock capture happens on the same edge as the lock write, so the time input is held steady around that write, and the captured value can be predicted exactly.

// File: rtl/hitcnt_pkg.sv
package hitcnt_pkg;
  localparam int DW       = 16;
  localparam int TS_W     = 64;
  localparam int CNT_W    = 2 * DW;
  localparam int MAX_CH   = 64;
  localparam int VEC_W    = 128;
  localparam logic [31:0] ID_WORD = 32'h2324ECE4;

  localparam logic [7:0] A_ID_LO  = 8'h00;
  localparam logic [7:0] A_ID_HI  = 8'h01;
  localparam logic [7:0] A_LOCK   = 8'h03;
  localparam logic [7:0] A_NCH    = 8'h08;
  localparam logic [4:0] A_MASK_W = 5'b00011;

  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/hitcnt_edge_det.sv
module hitcnt_edge_det #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmp_in,
  input  logic [NUM_CH-1:0] fall_sel,
  output logic [NUM_CH-1:0] level_o,
  output logic [NUM_CH-1:0] hit_o
);
  logic [NUM_CH-1:0] s1_q, s2_q, s3_q;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          s1_q[c] <= 1'b0;
          s2_q[c] <= 1'b0;
          s3_q[c] <= 1'b0;
        end else begin
          s1_q[c] <= cmp_in[c];
          s2_q[c] <= s1_q[c];
          s3_q[c] <= s2_q[c];
        end
      end
      assign hit_o[c] = fall_sel[c] ? (s3_q[c] & ~s2_q[c]) : (~s3_q[c] & s2_q[c]);
      assign level_o[c] = s2_q[c];

      // R8: a counted edge implies the synchronised level really moved
      assert_real_edge_R8: assert property (@(posedge clk) disable iff (rst)
        hit_o[c] |-> (level_o[c] != s3_q[c]));
    end
  endgenerate
endmodule

// File: rtl/hitcnt_counter_bank.sv
module hitcnt_counter_bank
  import hitcnt_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            hit,
  input  logic                         lock,
  input  logic                         snap,
  output logic [NUM_CH-1:0][CNT_W-1:0] view_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CH-1:0][CNT_W-1:0] shd_q;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[c] <= '0;
          shd_q[c] <= '0;
        end else begin
          if (hit[c]) cnt_q[c] <= cnt_q[c] + CNT_W'(1);
          if (snap)   shd_q[c] <= cnt_q[c];
        end
      end
      assign view_o[c] = lock ? shd_q[c] : cnt_q[c];

      assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[c] != $past(cnt_q[c])) |-> (cnt_q[c] == $past(cnt_q[c]) + CNT_W'(1)));
      assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        snap |=> (shd_q[c] == $past(cnt_q[c])));
      assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (lock && !snap) |=> $stable(shd_q[c]));
    end
  endgenerate
endmodule

// File: rtl/hitcnt_ctrl_regs.sv
module hitcnt_ctrl_regs
  import hitcnt_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  word_t             wdata,
  input  logic [TS_W-1:0]   time_now,
  output logic              lock_o,
  output logic              snap_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [TS_W-1:0]   ts_o
);
  logic              lock_q;
  logic [NUM_CH-1:0] mask_q;
  logic [TS_W-1:0]   ts_q;
  logic              lock_wr, mask_wr;

  assign lock_wr = wr && (addr == A_LOCK);
  assign mask_wr = wr && (addr[7:3] == A_MASK_W);
  assign snap_o  = lock_wr && wdata[0] && !lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      ts_q   <= '0;
    end else begin
      if (lock_wr) lock_q <= wdata[0];
      if (snap_o)  ts_q   <= time_now;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst) mask_q[c] <= 1'b0;
        else if (mask_wr && (addr[2:0] == 3'(c / DW))) mask_q[c] <= wdata[c % DW];
      end
    end
  endgenerate

  assign lock_o = lock_q;
  assign mask_o = mask_q;
  assign ts_o   = ts_q;

  assert_ts_capture_R4: assert property (@(posedge clk) disable iff (rst)
    snap_o |=> (ts_q == $past(time_now)));
  assert_ts_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !snap_o |=> $stable(ts_q));
  assert_lock_follow_R2: assert property (@(posedge clk) disable iff (rst)
    lock_wr |=> (lock_q == $past(wdata[0])));
endmodule

// File: rtl/hitcnt_read_port.sv
module hitcnt_read_port
  import hitcnt_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [7:0]                   addr,
  input  logic                         lock,
  input  logic [TS_W-1:0]              ts,
  input  logic [NUM_CH-1:0]            level,
  input  logic [NUM_CH-1:0]            mask,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  output word_t                        rdata
);
  logic [VEC_W-1:0]             lvl_w, mask_w;
  logic [MAX_CH-1:0][CNT_W-1:0] cnt_pad;
  word_t                        nxt;

  assign lvl_w  = VEC_W'(level);
  assign mask_w = VEC_W'(mask);

  genvar c;
  generate
    for (c = 0; c < MAX_CH; c++) begin : g_pad
      if (c < NUM_CH) begin : g_impl
        assign cnt_pad[c] = cnt[c];
      end else begin : g_none
        assign cnt_pad[c] = '0;
      end
    end
  endgenerate

  always_comb begin
    nxt = '0;
    casez (addr)
      A_ID_LO:      nxt = ID_WORD[15:0];
      A_ID_HI:      nxt = ID_WORD[31:16];
      A_LOCK:       nxt = {15'b0, lock};
      8'b0000_01??: nxt = ts[{addr[1:0], 4'b0000} +: DW];
      A_NCH:        nxt = DW'(NUM_CH);
      8'b0001_0???: nxt = lvl_w[{addr[2:0], 4'b0000} +: DW];
      8'b0001_1???: nxt = mask_w[{addr[2:0], 4'b0000} +: DW];
      8'b1???_????: nxt = cnt_pad[addr[6:1]][{addr[0], 4'b0000} +: DW];
      default:      nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

  assert_id_R1: assert property (@(posedge clk) disable iff (rst)
    (addr == A_ID_LO) |=> (rdata == 16'hECE4));
  assert_lock_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == A_LOCK) |=> (rdata[15:1] == 15'b0));
  assert_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h02 || addr[7:5] == 3'b001) |=> (rdata == '0));
endmodule

// File: rtl/hitcnt_regcore.sv
module hitcnt_regcore
  import hitcnt_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmp_in,
  input  logic [63:0]       time_now,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata
);
  logic [NUM_CH-1:0]            hit, level, mask;
  logic                         lock, snap;
  logic [TS_W-1:0]              ts;
  logic [NUM_CH-1:0][CNT_W-1:0] view;

  hitcnt_edge_det #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .fall_sel(mask),
    .level_o(level), .hit_o(hit));

  hitcnt_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .time_now(time_now), .lock_o(lock), .snap_o(snap), .mask_o(mask), .ts_o(ts));

  hitcnt_counter_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .hit(hit), .lock(lock), .snap(snap), .view_o(view));

  hitcnt_read_port #(.NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst(rst), .addr(reg_addr), .lock(lock), .ts(ts),
    .level(level), .mask(mask), .cnt(view), .rdata(reg_rdata));

  initial begin
    assert_nch_range_R5: assert (NUM_CH >= 1 && NUM_CH <= MAX_CH);
  end
endmodule

// File: tb/hitcnt_regcore_test.sv
`timescale 1ns/1ps
module hitcnt_regcore_test;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  cmp_in = '0;
  logic [63:0]     time_now = '0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic [15:0]     reg_wdata = '0;
  logic [15:0]     reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int unsigned exp_cnt [NCH];

  always #10 clk = ~clk;

  hitcnt_regcore #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .time_now(time_now),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'hFF; reg_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic read_cnt(input int ch, output logic [31:0] v);
    logic [15:0] lo, hi;
    bus_read(8'(8'h80 + 2 * ch), lo);
    bus_read(8'(8'h81 + 2 * ch), hi);
    v = {hi, lo};
  endtask

  task automatic check_all_counts(input string tag);
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      read_cnt(c, v);
      check(tag, v, exp_cnt[c]);
    end
  endtask

  task automatic pulse(input int ch);
    cmp_in[ch] = 1'b1; wait_cyc(4);
    cmp_in[ch] = 1'b0; wait_cyc(4);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);

    // R10: reset state
    for (int c = 0; c < NCH; c++) exp_cnt[c] = 0;
    check_all_counts("R10 counters after reset");
    bus_read(8'h18, d); check("R10 mask after reset", 32'(d), 32'h0);
    bus_read(8'h03, d); check("R10 lock after reset", 32'(d), 32'h0);
    for (int a = 4; a < 8; a++) begin
      bus_read(8'(a), d); check("R10 timestamp after reset", 32'(d), 32'h0);
    end

    // R1 / R5 / R9: constants and read-only/reserved offsets
    bus_write(8'h00, 16'h0000); bus_write(8'h01, 16'h0000);
    bus_read(8'h00, d); check("R1 id low", 32'(d), 32'hECE4);
    bus_read(8'h01, d); check("R1 id high", 32'(d), 32'h2324);
    bus_write(8'h08, 16'hFFFF);
    bus_read(8'h08, d); check("R5 channel count", 32'(d), NCH);
    bus_write(8'h02, 16'hFFFF); bus_write(8'h20, 16'hFFFF); bus_write(8'hA0, 16'hFFFF);
    bus_read(8'h02, d); check("R9 reserved 02h", 32'(d), 32'h0);
    bus_read(8'h20, d); check("R9 reserved 20h", 32'(d), 32'h0);
    bus_read(8'hA0, d); check("R9 unused channel A0h", 32'(d), 32'h0);
    bus_read(8'h03, d); check("R9 lock untouched", 32'(d), 32'h0);
    bus_write(8'h10, 16'hFFFF);
    bus_read(8'h10, d); check("R6 level read-only", 32'(d), 32'h0);

    // R7: polarity mask, channels 0..7 falling
    bus_write(8'h18, 16'h00FF); bus_write(8'h19, 16'hFFFF);
    bus_read(8'h18, d); check("R7 mask slice 0", 32'(d), 32'h00FF);
    bus_read(8'h19, d); check("R7 mask unimplemented slice", 32'(d), 32'h0);

    // R8: channel c gets c+1 full pulses (one counted edge each)
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p <= c; p++) pulse(c);
      exp_cnt[c] = c + 1;
    end
    check_all_counts("R8 pulse sweep");

    // R7 / R6: raise all lines, only rising channels advance
    cmp_in = '1; wait_cyc(4);
    for (int c = 0; c < NCH; c++) if (c >= 8) exp_cnt[c]++;
    check_all_counts("R7 rising polarity");
    bus_read(8'h10, d); check("R6 level all high", 32'(d), 32'hFFFF);
    bus_read(8'h11, d); check("R6 level unimplemented", 32'(d), 32'h0);
    cmp_in = 16'hA5C3; wait_cyc(4);
    bus_read(8'h10, d); check("R6 level pattern", 32'(d), 32'hA5C3);
    for (int c = 0; c < NCH; c++) if (!cmp_in[c] && c < 8) exp_cnt[c]++;
    cmp_in = '0; wait_cyc(4);
    for (int c = 0; c < NCH; c++) if (c < 8 && ((16'hA5C3 >> c) & 1)) exp_cnt[c]++;
    check_all_counts("R7 falling polarity");

    // R3 / R4 / R2: lock with a captured time value
    time_now = 64'hA1B2_C3D4_E5F6_0718;
    bus_write(8'h03, 16'hFFFF);
    time_now = 64'h0000_0000_0000_0001;
    bus_read(8'h03, d); check("R2 lock readback", 32'(d), 32'h0001);
    bus_read(8'h04, d); check("R4 ts 15:0", 32'(d), 32'h0718);
    bus_read(8'h05, d); check("R4 ts 31:16", 32'(d), 32'hE5F6);
    bus_read(8'h06, d); check("R4 ts 47:32", 32'(d), 32'hC3D4);
    bus_read(8'h07, d); check("R4 ts 63:48", 32'(d), 32'hA1B2);
    pulse(3); pulse(3); pulse(12);
    check_all_counts("R3 frozen while locked");
    bus_write(8'h03, 16'h0000);
    exp_cnt[3] += 2; exp_cnt[12] += 1;
    check_all_counts("R3 live after unlock");
    bus_read(8'h07, d); check("R4 ts held after unlock", 32'(d), 32'hA1B2);
    time_now = 64'h1111_2222_3333_4444;
    bus_write(8'h03, 16'h0001);
    bus_read(8'h04, d); check("R4 second capture", 32'(d), 32'h4444);
    read_cnt(3, v); check("R3 second snapshot", v, exp_cnt[3]);

    // R11: read data follows the address by one edge
    @(negedge clk); reg_addr = 8'h01;
    @(negedge clk); reg_addr = 8'h08;
    check("R11 first read", 32'(reg_rdata), 32'h2324);
    @(negedge clk);
    check("R11 second read", 32'(reg_rdata), NCH);

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1; wait_cyc(2); rst = 1'b0;
    for (int c = 0; c < NCH; c++) exp_cnt[c] = 0;
    check_all_counts("R10 counters after second reset");
    bus_read(8'h18, d); check("R10 mask cleared", 32'(d), 32'h0);
    bus_read(8'h03, d); check("R10 lock cleared", 32'(d), 32'h0);
    bus_read(8'h04, d); check("R10 ts cleared", 32'(d), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule